// File: doc/BRIEF.md
# SPI Master Message Engine

This block is a single-command SPI master. Software fills a transmit buffer, sets the length and kind of the main phase, and then writes a command word. That command word chooses a device and a number of write-only prefix bytes. The engine asserts that device's chip select and shifts the prefix bytes first. It then runs the main phase as full-duplex, read-only or write-only. When the last bit is done it releases the chip select and raises a done flag, which can drive an interrupt line.

Register map (8-bit address, 10-bit data):

| Address | Register | Contents |
|---------|----------|----------|
| 0x00 | config | bits[2:0] rate select, bit3 clock polarity, bit4 clock phase |
| 0x01 | message | bits[7:0] main byte count, bits[9:8] message type |
| 0x02 | command | bits[3:0] opcode, bits[7:4] prefix count, bits[9:8] device |
| 0x03 | status | bit0 done, bit1 busy |
| 0x04 | mask | bit0 enables the interrupt |
| 0x05 | receive tail | number of bytes stored |
| 0x40+i | transmit buffer | byte i (write) |
| 0x80+i | receive buffer | byte i (read) |

The sequencer moves through five named states:
- IDLE: waits for a launch.
- LOAD: fetches the next byte.
- LEAD: first half of each bit. Its end is the leading clock edge.
- TRAIL: second half of each bit. Its end is the trailing clock edge.
- STORE: ends each byte.

The transitions are:
- IDLE→LOAD on a launch with a non-zero total length.
- LOAD→LEAD.
- LEAD→TRAIL when the half-period timer expires.
- TRAIL→LEAD while bits remain in the byte.
- TRAIL→STORE after the eighth bit.
- STORE→LOAD while bytes remain.
- STORE→IDLE after the last byte.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset:
  - every chip select is high (inactive);
  - `sclk` is 0 and `mosi` is 0;
  - `irq` is low;
  - status, receive tail and config all read 0.

  Whenever no chip select is low, `sclk` equals the configured polarity and `mosi` is 0.
- R2: A command write launches a transfer only when bits[3:0] equal 4'hA and the engine is idle. Other opcodes are ignored. Writes to command, config or message while busy are also ignored.
- R3: During a command exactly one chip select line is low: `cs_n[dev]`, with dev taken from command bits[9:8]. It stays low for every byte of the command and returns high after the last byte.
- R4: The prefix count (command bits[7:4], 0 to 15) sets how many bytes are sent first. They come from transmit buffer offsets 0 upward. No receive data is captured during them.
- R5: The main phase length is message bits[7:0], saturated at the buffer depth (16). Its type is message bits[9:8]:
  - 0: full duplex;
  - 1: read only;
  - 2 or 3: write only.

  Main-phase transmit bytes continue from buffer offset prefix. In read-only mode `mosi` is held 0.
- R6: Each byte is 8 bits, shifted most significant bit first on both `mosi` and `miso`.
- R7: Clock phase 0 samples `miso` on the leading edge and changes `mosi` on the trailing edge. Clock phase 1 changes `mosi` on the leading edge and samples on the trailing edge. Clock polarity sets the idle level.
- R8: Each `sclk` half period lasts 2^k system clocks, where k is the rate select. A select of 7 behaves as 6, which gives seven rates.
- R9: In full-duplex and read modes, main-phase bytes are stored from receive offset 0 upward, and the receive tail then reads the main count. In write mode the tail reads 0.
- R10: Status bit0 (done) sets on the cycle the chip select is released. It is cleared only by writing 8'hFF to status bits[7:0]. `irq` is done AND mask bit0.
- R11: A launch with prefix and main count both 0 sets done without asserting any chip select.
- R12: Status bit1 (busy) is high from the cycle after a launch until the chip select is released. The config register does not change while busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register or buffer address |
| bus_wdata | input | 10 | Write data |
| bus_rdata | output | 10 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Done interrupt, gated by the mask |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The bench runs a behavioural serial slave that follows the configured polarity and phase. It replays one stream of bytes across both the prefix and the main phase. A design that captured during the prefix would therefore store shifted data and report the wrong receive tail. The runs cover the following corner cases, and what a broken design would show in each:
- The full 15-byte prefix with a full buffer: a wrong transmit offset would send main bytes from the wrong buffer location.
- A read-only command: a design that still drove `mosi` would send buffer contents instead of zeros.
- The out-of-range rate select: a design without the clamp would produce a 128-cycle or zero-length half period.
- A second command and a polarity change written mid-transfer: a design without busy blocking would glitch the chip select or the clock level, which the every-cycle idle monitor catches.
- A zero-length launch: a design that did not handle it would stall or pulse a chip select.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int BUS_W  = 10;
    localparam int ADDR_W = 8;

    localparam logic [7:0] A_CFG  = 8'h00;
    localparam logic [7:0] A_MSG  = 8'h01;
    localparam logic [7:0] A_CMD  = 8'h02;
    localparam logic [7:0] A_STAT = 8'h03;
    localparam logic [7:0] A_MASK = 8'h04;
    localparam logic [7:0] A_TAIL = 8'h05;

    localparam logic [1:0] TX_WIN = 2'b01;
    localparam logic [1:0] RX_WIN = 2'b10;

    localparam logic [3:0] OP_START  = 4'hA;
    localparam logic [7:0] CLEAR_ALL = 8'hFF;

    typedef enum logic [1:0] {
        MT_DUPLEX = 2'd0,
        MT_READ   = 2'd1,
        MT_WRITE  = 2'd2,
        MT_WRITE2 = 2'd3
    } msg_type_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_LEAD,
        ST_TRAIL,
        ST_STORE
    } seq_state_t;

    typedef struct packed {
        logic       cpha;
        logic       cpol;
        logic [2:0] rate;
    } spi_cfg_t;

endpackage

// File: rtl/spi_eng_regs.sv
module spi_eng_regs
    import spi_eng_pkg::*;
#(
    parameter  int BUF_DEPTH  = 16,
    parameter  int MAX_PREFIX = 15,
    localparam int TX_DEPTH   = BUF_DEPTH + MAX_PREFIX,
    localparam int TX_AW      = $clog2(TX_DEPTH),
    localparam int RX_AW      = $clog2(BUF_DEPTH),
    localparam int CNT_W      = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq,
    output logic              stat_done,
    output spi_cfg_t          cfg,
    output logic [CNT_W-1:0]  msg_count,
    output msg_type_t         msg_type,
    output logic              start,
    output logic [3:0]        cmd_prefix,
    output logic [1:0]        cmd_dev,
    input  logic              busy,
    input  logic              done_set,
    input  logic              rx_we,
    input  logic [7:0]        rx_wdata,
    input  logic [CNT_W-1:0]  rx_tail,
    input  logic [TX_AW-1:0]  tx_raddr,
    output logic [7:0]        tx_rdata
);

    logic [7:0] tx_mem [TX_DEPTH];
    logic [7:0] rx_mem [BUF_DEPTH];
    logic       mask_q;
    logic       tx_hit, rx_hit, cfg_wr, msg_wr, clr_wr;
    logic [CNT_W-1:0] count_in;

    assign tx_hit = (bus_addr[7:6] == TX_WIN) && (int'(bus_addr[5:0]) < TX_DEPTH);
    assign rx_hit = (bus_addr[7:6] == RX_WIN) && (int'(bus_addr[5:0]) < BUF_DEPTH);
    assign cfg_wr = bus_wr && (bus_addr == A_CFG) && !busy;
    assign msg_wr = bus_wr && (bus_addr == A_MSG) && !busy;
    assign clr_wr = bus_wr && (bus_addr == A_STAT) && (bus_wdata[7:0] == CLEAR_ALL);
    assign start  = bus_wr && (bus_addr == A_CMD) && (bus_wdata[3:0] == OP_START) && !busy;

    assign cmd_dev    = bus_wdata[9:8];
    assign cmd_prefix = (int'(bus_wdata[7:4]) > MAX_PREFIX) ? 4'(MAX_PREFIX) : bus_wdata[7:4];
    assign count_in   = (int'(bus_wdata[7:0]) > BUF_DEPTH) ? CNT_W'(BUF_DEPTH)
                                                           : bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg       <= '0;
            msg_count <= '0;
            msg_type  <= MT_DUPLEX;
            mask_q    <= 1'b0;
            stat_done <= 1'b0;
            for (int i = 0; i < TX_DEPTH; i++) tx_mem[i] <= '0;
            for (int i = 0; i < BUF_DEPTH; i++) rx_mem[i] <= '0;
        end else begin
            if (cfg_wr) cfg <= spi_cfg_t'(bus_wdata[4:0]);
            if (msg_wr) begin
                msg_count <= count_in;
                msg_type  <= msg_type_t'(bus_wdata[9:8]);
            end
            if (bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[0];
            if (done_set)    stat_done <= 1'b1;
            else if (clr_wr) stat_done <= 1'b0;
            if (bus_wr && tx_hit) tx_mem[bus_addr[TX_AW-1:0]] <= bus_wdata[7:0];
            if (rx_we) rx_mem[rx_tail[RX_AW-1:0]] <= rx_wdata;
        end
    end

    assign tx_rdata = tx_mem[tx_raddr];
    assign irq      = stat_done & mask_q;

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CFG:   bus_rdata = BUS_W'(cfg);
            A_MSG:   bus_rdata = {msg_type, 8'(msg_count)};
            A_STAT:  bus_rdata = {8'b0, busy, stat_done};
            A_MASK:  bus_rdata = {9'b0, mask_q};
            A_TAIL:  bus_rdata = BUS_W'(rx_tail);
            default: if (rx_hit) bus_rdata = {2'b0, rx_mem[bus_addr[RX_AW-1:0]]};
        endcase
    end

endmodule

// File: rtl/spi_eng_clkdiv.sv
module spi_eng_clkdiv #(
    parameter  int MAX_SEL = 6,
    localparam int DIV_W   = MAX_SEL + 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [2:0] sel,
    output logic       tick
);

    logic [2:0]       sel_eff;
    logic [DIV_W-1:0] limit, cnt;

    assign sel_eff = (int'(sel) > MAX_SEL) ? 3'(MAX_SEL) : sel;
    assign limit   = (DIV_W'(1) << sel_eff) - DIV_W'(1);
    assign tick    = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + DIV_W'(1);
    end

endmodule

// File: rtl/spi_eng_seq.sv
module spi_eng_seq
    import spi_eng_pkg::*;
#(
    parameter  int NUM_CS     = 4,
    parameter  int BUF_DEPTH  = 16,
    parameter  int MAX_PREFIX = 15,
    localparam int TX_DEPTH   = BUF_DEPTH + MAX_PREFIX,
    localparam int TX_AW      = $clog2(TX_DEPTH),
    localparam int CNT_W      = $clog2(BUF_DEPTH + 1),
    localparam int IDX_W      = $clog2(TX_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [3:0]        cmd_prefix,
    input  logic [1:0]        cmd_dev,
    input  logic [CNT_W-1:0]  msg_count,
    input  msg_type_t         msg_type,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              tick,
    input  logic [7:0]        tx_rdata,
    input  logic              miso,
    output logic              busy,
    output logic              run,
    output logic [TX_AW-1:0]  tx_raddr,
    output logic              rx_we,
    output logic [7:0]        rx_wdata,
    output logic [CNT_W-1:0]  rx_tail,
    output logic              done_set,
    output logic [NUM_CS-1:0] cs_n,
    output logic              sclk,
    output logic              mosi
);

    seq_state_t       state, nxt;
    logic [IDX_W-1:0] byte_idx, total_q, total_in;
    logic [3:0]       pre_q;
    msg_type_t        type_q;
    logic [2:0]       bit_cnt;
    logic [7:0]       tx_sh, rx_sh, load_byte;
    logic             sclk_q, in_prefix, capture, last_byte;

    assign total_in  = IDX_W'(cmd_prefix) + IDX_W'(msg_count);
    assign in_prefix = byte_idx < IDX_W'(pre_q);
    assign capture   = !in_prefix && (type_q == MT_DUPLEX || type_q == MT_READ);
    assign last_byte = (byte_idx + IDX_W'(1)) == total_q;
    assign load_byte = (in_prefix || type_q != MT_READ) ? tx_rdata : 8'h00;

    assign busy     = (state != ST_IDLE);
    assign run      = (state == ST_LEAD) || (state == ST_TRAIL);
    assign tx_raddr = byte_idx[TX_AW-1:0];
    assign rx_we    = (state == ST_STORE) && capture;
    assign rx_wdata = rx_sh;
    assign done_set = ((state == ST_IDLE) && start && total_in == '0) ||
                      ((state == ST_STORE) && last_byte);
    assign sclk     = (state == ST_IDLE) ? cpol : sclk_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start && total_in != '0) nxt = ST_LOAD;
            ST_LOAD:  nxt = ST_LEAD;
            ST_LEAD:  if (tick) nxt = ST_TRAIL;
            ST_TRAIL: if (tick) nxt = (bit_cnt == 3'd0) ? ST_STORE : ST_LEAD;
            ST_STORE: nxt = last_byte ? ST_IDLE : ST_LOAD;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_idx <= '0;
            total_q  <= '0;
            pre_q    <= '0;
            type_q   <= MT_DUPLEX;
            bit_cnt  <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_tail  <= '0;
            cs_n     <= '1;
            sclk_q   <= 1'b0;
            mosi     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    sclk_q <= cpol;
                    mosi   <= 1'b0;
                    if (start) begin
                        byte_idx <= '0;
                        total_q  <= total_in;
                        pre_q    <= cmd_prefix;
                        type_q   <= msg_type;
                        rx_tail  <= '0;
                        if (total_in != '0) cs_n <= ~(NUM_CS'(1) << cmd_dev);
                    end
                end
                ST_LOAD: begin
                    bit_cnt <= 3'd7;
                    if (cpha) tx_sh <= load_byte;
                    else begin
                        mosi  <= load_byte[7];
                        tx_sh <= {load_byte[6:0], 1'b0};
                    end
                end
                ST_LEAD: if (tick) begin
                    sclk_q <= ~cpol;
                    if (!cpha) rx_sh <= {rx_sh[6:0], miso};
                    else begin
                        mosi  <= tx_sh[7];
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
                ST_TRAIL: if (tick) begin
                    sclk_q  <= cpol;
                    bit_cnt <= bit_cnt - 3'd1;
                    if (cpha) rx_sh <= {rx_sh[6:0], miso};
                    else if (bit_cnt != 3'd0) begin
                        mosi  <= tx_sh[7];
                        tx_sh <= {tx_sh[6:0], 1'b0};
                    end
                end
                ST_STORE: begin
                    byte_idx <= byte_idx + IDX_W'(1);
                    if (capture) rx_tail <= rx_tail + CNT_W'(1);
                    if (last_byte) begin
                        cs_n <= '1;
                        mosi <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_eng_pkg::*;
#(
    parameter  int NUM_CS     = 4,
    parameter  int BUF_DEPTH  = 16,
    parameter  int MAX_PREFIX = 15,
    parameter  int MAX_SEL    = 6,
    localparam int TX_DEPTH   = BUF_DEPTH + MAX_PREFIX,
    localparam int TX_AW      = $clog2(TX_DEPTH),
    localparam int CNT_W      = $clog2(BUF_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [9:0]        bus_wdata,
    output logic [9:0]        bus_rdata,
    output logic              irq,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [NUM_CS-1:0] cs_n
);

    spi_cfg_t         cfg;
    msg_type_t        msg_type;
    logic [CNT_W-1:0] msg_count, rx_tail;
    logic [3:0]       cmd_prefix;
    logic [1:0]       cmd_dev;
    logic             start, busy, run, tick, done_set, rx_we, stat_done;
    logic [7:0]       rx_wdata, tx_rdata;
    logic [TX_AW-1:0] tx_raddr;

    spi_eng_regs #(.BUF_DEPTH(BUF_DEPTH), .MAX_PREFIX(MAX_PREFIX)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .stat_done(stat_done),
        .cfg(cfg), .msg_count(msg_count), .msg_type(msg_type), .start(start),
        .cmd_prefix(cmd_prefix), .cmd_dev(cmd_dev), .busy(busy), .done_set(done_set),
        .rx_we(rx_we), .rx_wdata(rx_wdata), .rx_tail(rx_tail),
        .tx_raddr(tx_raddr), .tx_rdata(tx_rdata)
    );

    spi_eng_clkdiv #(.MAX_SEL(MAX_SEL)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(cfg.rate), .tick(tick)
    );

    spi_eng_seq #(.NUM_CS(NUM_CS), .BUF_DEPTH(BUF_DEPTH), .MAX_PREFIX(MAX_PREFIX)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_prefix(cmd_prefix),
        .cmd_dev(cmd_dev), .msg_count(msg_count), .msg_type(msg_type),
        .cpol(cfg.cpol), .cpha(cfg.cpha), .tick(tick), .tx_rdata(tx_rdata),
        .miso(miso), .busy(busy), .run(run), .tx_raddr(tx_raddr), .rx_we(rx_we),
        .rx_wdata(rx_wdata), .rx_tail(rx_tail), .done_set(done_set),
        .cs_n(cs_n), .sclk(sclk), .mosi(mosi)
    );

endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
    parameter  int NUM_CS    = 4,
    parameter  int BUF_DEPTH = 16,
    localparam int CNT_W     = $clog2(BUF_DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CS-1:0] cs_n,
    input logic              busy,
    input logic              done,
    input logic              cpol,
    input logic [CNT_W-1:0]  rx_tail
);

    a_r3_one_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    a_r12_cs_means_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |-> busy);

    a_r10_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (&cs_n));

    a_r9_tail_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(rx_tail) <= BUF_DEPTH);

    a_r12_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cpol));

endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(.NUM_CS(NUM_CS), .BUF_DEPTH(BUF_DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .busy(u_seq.busy),
    .done(u_regs.stat_done), .cpol(u_regs.cfg.cpol), .rx_tail(u_seq.rx_tail)
);

// File: tb/spi_cmd_engine_test.sv
module spi_cmd_engine_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [9:0] bus_wdata = '0;
    logic [9:0] bus_rdata;
    logic       irq, sclk, mosi;
    logic       miso = 1'b0;
    logic [3:0] cs_n;

    spi_cmd_engine uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // bench-side view of configuration and serial slave state
    logic       b_cpol = 1'b0;
    logic       b_cpha = 1'b0;
    logic [7:0] s_tx[$];
    logic [7:0] got[$];
    logic [3:0] cs_seen = '0;
    int         cs_falls = 0;
    int         mon_err = 0;
    bit         s_active = 1'b0;
    int         s_bit = 0;
    int         s_nb = 0;
    logic [7:0] s_rx = '0;
    time        t_lead = 0;
    int         hp_min = 1000000;
    int         hp_max = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic slave_bit(input int p);
        if (p / 8 < s_tx.size()) return s_tx[p / 8][7 - (p % 8)];
        return 1'b0;
    endfunction

    // serial slave: chip select activity
    always @(cs_n) begin
        if ($countones(~cs_n) > 1) mon_err++;
        if (!(&cs_n) && !s_active) begin
            s_active = 1'b1;
            cs_seen  = cs_seen | ~cs_n;
            cs_falls++;
            s_bit = 0;
            s_nb  = 0;
            if (!b_cpha) begin
                miso  = slave_bit(0);
                s_bit = 1;
            end
        end else if (&cs_n) begin
            s_active = 1'b0;
        end
    end

    // serial slave: clock edges
    always @(sclk) begin
        if (s_active) begin
            automatic bit lead = (sclk != b_cpol);
            if (lead) t_lead = $time;
            else begin
                automatic int hp = int'(($time - t_lead) / 20);
                if (hp < hp_min) hp_min = hp;
                if (hp > hp_max) hp_max = hp;
            end
            if (lead == !b_cpha) begin
                s_rx = {s_rx[6:0], mosi};
                s_nb++;
                if (s_nb == 8) begin
                    got.push_back(s_rx);
                    s_nb = 0;
                end
            end else begin
                miso = slave_bit(s_bit);
                s_bit++;
            end
        end
    end

    // every-clock idle comparison against the bench's configuration
    always @(posedge clk) begin
        #5;
        if (rst_n && (&cs_n) && (sclk !== b_cpol || mosi !== 1'b0)) mon_err++;
    end

    task automatic wr(input logic [7:0] a, input logic [9:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [9:0] v);
        @(negedge clk);
        bus_addr = a;
        #2 v = bus_rdata;
    endtask

    function automatic logic [7:0] txv(input int i, input int seed);
        return 8'(i * 29 + seed * 7 + 3);
    endfunction

    task automatic wait_done(output bit ok);
        logic [9:0] v;
        ok = 1'b0;
        for (int n = 0; n < 20000; n++) begin
            rd(8'h03, v);
            if (v[0]) begin ok = 1'b1; break; end
        end
    endtask

    task automatic run_cmd(input int dev, input int pre, input int cnt, input int typ,
                           input int rate, input bit cpol, input bit cpha,
                           input int seed, input bit poke);
        logic [9:0] v;
        bit ok;
        int falls0;
        int exp_hp;
        b_cpol = cpol;
        b_cpha = cpha;
        wr(8'h00, 10'((int'(cpha) << 4) | (int'(cpol) << 3) | rate));
        for (int i = 0; i < pre + cnt; i++) wr(8'h40 + 8'(i), 10'(txv(i, seed)));
        s_tx.delete();
        for (int i = 0; i < pre + cnt; i++) s_tx.push_back(8'((i * 53) ^ (seed + 8'h11)));
        got.delete();
        cs_seen = '0;
        hp_min = 1000000;
        hp_max = 0;
        mon_err = 0;
        falls0 = cs_falls;
        wr(8'h01, 10'((typ << 8) | cnt));
        wr(8'h03, 10'hFF);
        wr(8'h04, 10'h1);
        wr(8'h02, 10'((dev << 8) | (pre << 4) | 4'hA));
        rd(8'h03, v);
        chk(v[1] == 1'b1, "R12 busy after launch", int'(v[1]), 1);
        if (poke) begin
            wr(8'h02, 10'(((dev ^ 1) << 8) | 4'hA));
            wr(8'h00, 10'((int'(cpha) << 4) | (int'(!cpol) << 3) | rate));
            wr(8'h01, 10'h005);
        end
        wait_done(ok);
        chk(ok, "R10 done set", int'(ok), 1);
        #1;
        chk(irq == 1'b1, "R10 irq with mask", int'(irq), 1);
        rd(8'h03, v);
        chk(v[1] == 1'b0, "R12 busy clear at end", int'(v[1]), 0);
        chk(cs_falls - falls0 == 1 && cs_seen == 4'(1 << dev), "R3 single select",
            int'(cs_seen), 1 << dev);
        chk(mon_err == 0, "R1 idle levels and one select each clock", mon_err, 0);
        chk(got.size() == pre + cnt, "R6 byte count on wire", got.size(), pre + cnt);
        for (int j = 0; j < pre + cnt && j < got.size(); j++) begin
            automatic logic [7:0] e = (j >= pre && typ == 1) ? 8'h00 : txv(j, seed);
            chk(got[j] == e, (j < pre) ? "R4 prefix byte" : "R5 main byte",
                int'(got[j]), int'(e));
        end
        rd(8'h05, v);
        chk(int'(v) == ((typ <= 1) ? cnt : 0), "R9 receive tail", int'(v),
            (typ <= 1) ? cnt : 0);
        if (typ <= 1) begin
            for (int j = 0; j < cnt; j++) begin
                rd(8'h80 + 8'(j), v);
                chk(v[7:0] == s_tx[pre + j], "R7 received byte", int'(v[7:0]),
                    int'(s_tx[pre + j]));
            end
        end
        exp_hp = 1 << ((rate > 6) ? 6 : rate);
        chk(hp_min == exp_hp && hp_max == exp_hp, "R8 half period", hp_max, exp_hp);
        if (poke) begin
            rd(8'h00, v);
            chk(v[3] == cpol, "R2 config held while busy", int'(v[3]), int'(cpol));
            rd(8'h01, v);
            chk(int'(v) == ((typ << 8) | cnt), "R2 message held while busy", int'(v),
                (typ << 8) | cnt);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [9:0] v;
        bit ok;
        int f0;
        repeat (3) @(posedge clk);
        #3 rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 4'hF && sclk == 1'b0 && mosi == 1'b0 && irq == 1'b0,
            "R1 reset pins", int'({cs_n, sclk, mosi, irq}), 'h78);
        rd(8'h03, v);
        chk(v == '0, "R1 reset status", int'(v), 0);
        rd(8'h05, v);
        chk(v == '0, "R1 reset tail", int'(v), 0);
        rd(8'h00, v);
        chk(v == '0, "R1 reset config", int'(v), 0);

        run_cmd(0, 0, 4, 0, 0, 1'b0, 1'b0, 1, 1'b0);
        run_cmd(1, 3, 5, 1, 1, 1'b1, 1'b0, 2, 1'b0);
        run_cmd(2, 2, 6, 2, 0, 1'b0, 1'b1, 3, 1'b1);
        run_cmd(3, 15, 16, 0, 0, 1'b1, 1'b1, 4, 1'b0);
        run_cmd(0, 1, 2, 3, 2, 1'b1, 1'b0, 5, 1'b0);
        run_cmd(1, 0, 2, 1, 7, 1'b0, 1'b1, 6, 1'b0);

        // R10: only the clear-all value clears done; mask gates irq
        wr(8'h03, 10'h001);
        rd(8'h03, v);
        chk(v[0] == 1'b1, "R10 partial clear ignored", int'(v[0]), 1);
        wr(8'h04, 10'h0);
        #1 chk(irq == 1'b0, "R10 masked irq", int'(irq), 0);
        wr(8'h04, 10'h1);
        wr(8'h03, 10'hFF);
        rd(8'h03, v);
        chk(v[0] == 1'b0 && irq == 1'b0, "R10 clear all", int'(v[0]), 0);

        // R2: a wrong opcode does nothing
        f0 = cs_falls;
        wr(8'h01, 10'h003);
        wr(8'h02, 10'h105);
        repeat (20) @(negedge clk);
        rd(8'h03, v);
        chk(cs_falls == f0 && v == '0, "R2 bad opcode ignored", int'(v), 0);

        // R11: zero-length launch
        wr(8'h01, 10'h000);
        wr(8'h02, 10'h00A);
        wait_done(ok);
        chk(ok && cs_falls == f0, "R11 zero length done without select",
            cs_falls - f0, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule